// File: doc/BRIEF.md
# Multidrop UART Address-Filtering Receiver

This block receives asynchronous serial frames on a shared multi-drop line. Each frame has one start bit, eight data bits sent least significant bit first, a ninth bit in the slot a parity bit would take, and one stop bit. The ninth bit tells the receiver what kind of byte it has. A 1 marks an address byte and a 0 marks a data byte. The receiver does no parity checking, and the word length is fixed at eight bits.

Each address byte is compared with a programmed node address under a programmed mask. A match opens the node: the address byte and every data byte after it are delivered. A later address byte that does not match closes the node again, and data bytes are then dropped. Delivered bytes come out as a one-cycle strobe, with the byte and a flag that tells address bytes from data bytes.

Top module: `mdrop_rx_top`

## Requirements
- R1: After reset, `out_valid` and `frame_err` are low, the node is closed, the node address is 0x00 and the mask is 0xFF. A reset in the middle of traffic brings back all of these values.
- R2: Line sampling runs at 16 ticks per bit. A falling edge starts a frame only if the line is still low eight ticks later, at the middle of the start bit. A shorter low pulse produces no output and no error.
- R3: The frame order is start (0), data bits 0 to 7, qualifier, stop (1). `out_byte` bit i equals data bit i as it was sent.
- R4: A byte whose qualifier is 1 matches when ((byte XOR address) AND mask) == 0. Mask bits that are 0 take no part in the compare.
- R5: With the reset mask 0xFF, only the exact programmed address matches.
- R6: A matching address byte is delivered with `out_is_addr` = 1 and opens the node.
- R7: While the node is open, each byte whose qualifier is 0 is delivered with `out_is_addr` = 0.
- R8: A non-matching address byte is not delivered and closes the node. Data bytes after it are not delivered.
- R9: Before any matching address byte has been seen after reset, data bytes are not delivered.
- R10: A frame whose stop bit samples low raises `frame_err` for exactly one cycle, is not delivered, and leaves the node open or closed as it was. The receiver waits for the line to return high before it looks for a new start bit.
- R11: Each delivered byte gives exactly one single-cycle `out_valid` pulse, and `out_valid` is never high in the same cycle as `frame_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idles high, asynchronous to clk |
| cfg_addr_we | input | 1 | Write strobe for the node address |
| cfg_addr | input | 8 | New node address |
| cfg_mask_we | input | 1 | Write strobe for the compare mask |
| cfg_mask | input | 8 | New compare mask |
| out_valid | output | 1 | One-cycle strobe for a delivered byte |
| out_byte | output | 8 | Delivered byte |
| out_is_addr | output | 1 | 1 when the delivered byte is an address byte |
| frame_err | output | 1 | One-cycle pulse when a stop bit samples low |

## Verification
The bench sends data bytes before any address has matched. A design that starts with the node open would pass them through. It sends an address one bit away from the programmed value while the mask is still at its reset value, which a mask that resets to zero would accept. A widened mask is then tested with one address that must match and one that must not, and a reset in the middle of traffic must put the mask back to exact matching. A short low glitch on the line catches a receiver that does not confirm the start bit at its midpoint. A frame with a bad stop bit, sent while the node is open and followed by a good data byte, catches a receiver that delivers the bad byte, changes the node state, or reads the low stop bit as a new start.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_QUAL,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    typedef enum logic {
        FLT_IGNORE,
        FLT_ACCEPT
    } flt_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              qual;
        logic              stop_ok;
    } rx_frame_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] rx_b,
                                      input logic [BYTE_W-1:0] node,
                                      input logic [BYTE_W-1:0] msk);
        return ((rx_b ^ node) & msk) == '0;
    endfunction

endpackage

// File: rtl/mdrop_tick_gen.sv
module mdrop_tick_gen #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [W-1:0] LAST = W'(TICK_DIV - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/mdrop_bit_rx.sv
module mdrop_bit_rx
    import mdrop_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rxd_async,
    output rx_frame_t frm,
    output logic      frm_vld
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] TOP  = IDX_W'(BYTE_W - 1);

    logic [1:0]        sync_q;
    logic              rxd;
    rx_state_e         st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rxd_async};
    end
    assign rxd = sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= RX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
            frm     <= '0;
            frm_vld <= 1'b0;
        end else begin
            frm_vld <= 1'b0;
            if (tick) begin
                case (st_q)
                    RX_IDLE: begin
                        if (!rxd) begin
                            st_q  <= RX_START;
                            cnt_q <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt_q == MID) begin
                            cnt_q <= '0;
                            idx_q <= '0;
                            st_q  <= rxd ? RX_IDLE : RX_DATA;
                        end else cnt_q <= cnt_q + 1'b1;
                    end
                    RX_DATA: begin
                        if (cnt_q == LAST) begin
                            cnt_q <= '0;
                            sh_q  <= {rxd, sh_q[BYTE_W-1:1]};
                            if (idx_q == TOP) st_q <= RX_QUAL;
                            else              idx_q <= idx_q + 1'b1;
                        end else cnt_q <= cnt_q + 1'b1;
                    end
                    RX_QUAL: begin
                        if (cnt_q == LAST) begin
                            cnt_q    <= '0;
                            frm.qual <= rxd;
                            st_q     <= RX_STOP;
                        end else cnt_q <= cnt_q + 1'b1;
                    end
                    RX_STOP: begin
                        if (cnt_q == LAST) begin
                            cnt_q       <= '0;
                            frm.data    <= sh_q;
                            frm.stop_ok <= rxd;
                            frm_vld     <= 1'b1;
                            st_q        <= rxd ? RX_IDLE : RX_HOLD;
                        end else cnt_q <= cnt_q + 1'b1;
                    end
                    RX_HOLD: begin
                        if (rxd) st_q <= RX_IDLE;
                    end
                    default: st_q <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter
    import mdrop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_addr_we,
    input  logic [BYTE_W-1:0] cfg_addr,
    input  logic              cfg_mask_we,
    input  logic [BYTE_W-1:0] cfg_mask,
    input  rx_frame_t         frm,
    input  logic              frm_vld,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_is_addr,
    output logic              frame_err,
    output flt_state_e        flt_st,
    output logic [BYTE_W-1:0] node_addr_q,
    output logic [BYTE_W-1:0] node_mask_q
);
    logic hit;
    assign hit = addr_hit(frm.data, node_addr_q, node_mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            node_addr_q <= '0;
            node_mask_q <= '1;
        end else begin
            if (cfg_addr_we) node_addr_q <= cfg_addr;
            if (cfg_mask_we) node_mask_q <= cfg_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flt_st      <= FLT_IGNORE;
            out_valid   <= 1'b0;
            out_byte    <= '0;
            out_is_addr <= 1'b0;
            frame_err   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            frame_err <= 1'b0;
            if (frm_vld) begin
                if (!frm.stop_ok) begin
                    frame_err <= 1'b1;
                end else if (frm.qual) begin
                    flt_st      <= hit ? FLT_ACCEPT : FLT_IGNORE;
                    out_valid   <= hit;
                    out_byte    <= frm.data;
                    out_is_addr <= 1'b1;
                end else if (flt_st == FLT_ACCEPT) begin
                    out_valid   <= 1'b1;
                    out_byte    <= frm.data;
                    out_is_addr <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/mdrop_rx_top.sv
module mdrop_rx_top
    import mdrop_pkg::*;
#(
    parameter int OVS      = 16,
    parameter int TICK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rxd,
    input  logic       cfg_addr_we,
    input  logic [7:0] cfg_addr,
    input  logic       cfg_mask_we,
    input  logic [7:0] cfg_mask,
    output logic       out_valid,
    output logic [7:0] out_byte,
    output logic       out_is_addr,
    output logic       frame_err
);
    logic              tick;
    rx_frame_t         frm;
    logic              frm_vld;
    flt_state_e        flt_st;
    logic [BYTE_W-1:0] node_addr_q;
    logic [BYTE_W-1:0] node_mask_q;

    mdrop_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    mdrop_bit_rx #(.OVS(OVS)) bitrx_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .rxd_async (rxd),
        .frm       (frm),
        .frm_vld   (frm_vld)
    );

    mdrop_addr_filter filt_i (
        .clk         (clk),
        .rst         (rst),
        .cfg_addr_we (cfg_addr_we),
        .cfg_addr    (cfg_addr),
        .cfg_mask_we (cfg_mask_we),
        .cfg_mask    (cfg_mask),
        .frm         (frm),
        .frm_vld     (frm_vld),
        .out_valid   (out_valid),
        .out_byte    (out_byte),
        .out_is_addr (out_is_addr),
        .frame_err   (frame_err),
        .flt_st      (flt_st),
        .node_addr_q (node_addr_q),
        .node_mask_q (node_mask_q)
    );
endmodule

// File: rtl/mdrop_rx_chk.sv
module mdrop_rx_chk
    import mdrop_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              out_valid,
    input logic [BYTE_W-1:0] out_byte,
    input logic              out_is_addr,
    input logic              frame_err,
    input rx_frame_t         frm,
    input logic              frm_vld,
    input flt_state_e        flt_st,
    input logic [BYTE_W-1:0] node_addr_q,
    input logic [BYTE_W-1:0] node_mask_q
);
    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R11
    excl_out_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> !out_valid);

    // R10
    err_source_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> ($past(frm_vld) && !$past(frm.stop_ok)));

    // R10
    err_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> $stable(flt_st));

    // R3
    byte_path_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(frm_vld) && out_byte == $past(frm.data)));

    // R6
    addr_opens_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_is_addr) |-> (flt_st == FLT_ACCEPT && $past(frm.qual)));

    // R7
    data_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_is_addr) |-> ($past(flt_st) == FLT_ACCEPT));

    // R8
    miss_closes_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && frm.stop_ok && frm.qual &&
         (((frm.data ^ node_addr_q) & node_mask_q) != '0))
        |=> (!out_valid && flt_st == FLT_IGNORE));
endmodule

bind mdrop_rx_top mdrop_rx_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .out_valid   (out_valid),
    .out_byte    (out_byte),
    .out_is_addr (out_is_addr),
    .frame_err   (frame_err),
    .frm         (frm),
    .frm_vld     (frm_vld),
    .flt_st      (flt_st),
    .node_addr_q (node_addr_q),
    .node_mask_q (node_mask_q)
);

// File: tb/mdrop_rx_top_tb_top.sv
module mdrop_rx_top_tb_top;
    localparam int OVS      = 16;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = OVS * TICK_DIV;
    localparam int NVEC     = 9;
    // {expect delivered, qualifier, byte}
    localparam logic [9:0] VEC [NVEC] = '{
        10'b0_0_00010001,   // R9  data before any match
        10'b0_1_01011011,   // R5  0x5B rejected, mask 0xFF
        10'b1_1_01011010,   // R6  0x5A matches
        10'b1_0_10100111,   // R7  R3 0xA7 bit order
        10'b1_0_00000001,   // R7
        10'b0_1_01011100,   // R8  0x5C closes node
        10'b0_0_10000000,   // R8  dropped
        10'b1_1_01011010,   // R6
        10'b1_0_11111110    // R7
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       cfg_addr_we = 1'b0;
    logic [7:0] cfg_addr = 8'h00;
    logic       cfg_mask_we = 1'b0;
    logic [7:0] cfg_mask = 8'h00;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       out_is_addr;
    logic       frame_err;

    int n_chk = 0;
    int n_bad = 0;
    int n_val = 0;
    int n_err = 0;
    logic [7:0] cap_b = 8'h00;
    logic       cap_a = 1'b0;
    int v0, e0;

    always #4 clk = ~clk;

    mdrop_rx_top #(.OVS(OVS), .TICK_DIV(TICK_DIV)) dut_i (
        .clk(clk), .rst(rst), .rxd(rxd),
        .cfg_addr_we(cfg_addr_we), .cfg_addr(cfg_addr),
        .cfg_mask_we(cfg_mask_we), .cfg_mask(cfg_mask),
        .out_valid(out_valid), .out_byte(out_byte),
        .out_is_addr(out_is_addr), .frame_err(frame_err)
    );

    always @(negedge clk) begin
        if (out_valid) begin
            n_val <= n_val + 1;
            cap_b <= out_byte;
            cap_a <= out_is_addr;
        end
        if (frame_err) n_err <= n_err + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v);
        rxd = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic q, input logic stp);
        @(negedge clk);
        v0 = n_val;
        e0 = n_err;
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(b[i]);
        drive_bit(q);
        drive_bit(stp);
        drive_bit(1'b1);
        drive_bit(1'b1);
    endtask

    task automatic expect_frame(input string tag, input int nv, input logic [7:0] b, input logic a);
        check(n_val - v0 == nv, tag, n_val - v0, nv);
        check(n_err - e0 == 0, {tag, " no frame error"}, n_err - e0, 0);
        if (nv == 1) begin
            check(cap_b == b, {tag, " byte"}, cap_b, b);
            check(cap_a == a, {tag, " addr flag"}, cap_a, a);
        end
    endtask

    task automatic write_cfg(input bit wa, input logic [7:0] a, input bit wm, input logic [7:0] m);
        @(negedge clk);
        cfg_addr_we = wa; cfg_addr = a;
        cfg_mask_we = wm; cfg_mask = m;
        @(negedge clk);
        cfg_addr_we = 1'b0;
        cfg_mask_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset outputs
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        check(frame_err == 1'b0, "R1 frame_err after reset", frame_err, 0);

        write_cfg(1'b1, 8'h5A, 1'b0, 8'h00);
        for (int k = 0; k < NVEC; k++) begin
            send(VEC[k][7:0], VEC[k][8], 1'b1);
            expect_frame($sformatf("R6/R7/R8 vector %0d", k), int'(VEC[k][9]), VEC[k][7:0], VEC[k][8]);
        end

        // R2 short glitch while node is open
        @(negedge clk);
        v0 = n_val; e0 = n_err;
        rxd = 1'b0;
        repeat (3 * TICK_DIV) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        check(n_val - v0 == 0, "R2 glitch delivers nothing", n_val - v0, 0);
        check(n_err - e0 == 0, "R2 glitch raises no error", n_err - e0, 0);
        send(8'h3C, 1'b0, 1'b1);
        expect_frame("R2 frame after glitch", 1, 8'h3C, 1'b0);

        // R10 bad stop bit while open
        send(8'h77, 1'b0, 1'b0);
        check(n_err - e0 == 1, "R10 frame_err pulse", n_err - e0, 1);
        check(n_val - v0 == 0, "R10 bad frame dropped", n_val - v0, 0);
        send(8'h99, 1'b0, 1'b1);
        expect_frame("R10 node still open", 1, 8'h99, 1'b0);

        // R4 widened mask
        write_cfg(1'b1, 8'h50, 1'b1, 8'hF0);
        send(8'h5F, 1'b1, 1'b1);
        expect_frame("R4 masked match", 1, 8'h5F, 1'b1);
        send(8'h60, 1'b1, 1'b1);
        expect_frame("R4 masked miss", 0, 8'h00, 1'b0);
        send(8'h12, 1'b0, 1'b1);
        expect_frame("R8 data after miss", 0, 8'h00, 1'b0);
        send(8'h53, 1'b1, 1'b1);
        expect_frame("R4 masked match again", 1, 8'h53, 1'b1);

        // R1 reset during traffic: node closed, address 0x00, mask 0xFF
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        rst = 1'b0;
        send(8'h21, 1'b0, 1'b1);
        expect_frame("R1 R9 closed after reset", 0, 8'h00, 1'b0);
        send(8'h0F, 1'b1, 1'b1);
        expect_frame("R1 mask back to 0xFF", 0, 8'h00, 1'b0);
        send(8'h00, 1'b1, 1'b1);
        expect_frame("R1 address back to 0x00", 1, 8'h00, 1'b1);
        send(8'hC5, 1'b0, 1'b1);
        expect_frame("R7 data after reset match", 1, 8'hC5, 1'b0);

        finish_run();
    end
endmodule